// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer Core

This block is the timing core of a three-channel motor-control PWM generator. A free-running counter steps through one switching period. The period length in system clocks is taken from a programmable period value. For each of three channels the core drives a raw pulse that is high for the programmed on-time and is centred in the period. A one-clock sync strobe marks the first clock of every period. Deadtime, complement outputs, pulse deletion and shutdown are left to a downstream output stage.

Software writes the period and the three on-times through a single write port. On-time writes go into staging registers. A staged set is accepted only once all three channels have been written. It must also be complete five counts before the period ends. The last four counts of each period are reserved for computing the new edge positions. The new edges then take effect together at the next period boundary. A status output shows that an accepted set is waiting for that boundary.

Top module: `pwm3_core`

## Requirements
- R1: The period register is written with `wr_sel` = 0. A value accepted before a period's snapshot point (count P-5) sets the length of the following period, and sync pulses are then that many clocks apart. Legal values lie between 8 and 4095.
- R2: `sync_o` is high for exactly one clock, the clock in which the period count is 0.
- R3: For a channel with on-time N < P, the raw pulse is high for the counts from (P-N)/2 (rounded down) to (P-N)/2+N-1, so it is high for exactly N clocks per period. P is the period used for that commit. Channel A is written with `wr_sel` = 1, B with 2 and C with 3, and they map to `pulse_o[0]`, `pulse_o[1]` and `pulse_o[2]`.
- R4: An on-time of 0 holds the channel low for the whole period.
- R5: An on-time greater than or equal to the period holds the channel high for the whole period.
- R6: New on-times take effect only after all three channels have been written since the last accepted set. A partial set leaves every output unchanged.
- R7: A set completed by a write presented while the count is P-5 or lower takes effect at the next period start. A set completed by a write in the last four counts (P-4 to P-1) takes effect one period later.
- R8: `set_pending_o` rises on the clock after a complete set is accepted. It is low again in the sync clock where that set takes effect.
- R9: After reset the count is 0, the period is 500, all pulses are low, and the status is clear. The logic starts running on the third clock edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one register |
| wr_sel | input | 2 | Target: 0 period, 1 channel A, 2 channel B, 3 channel C |
| wr_data | input | 12 | Value written |
| sync_o | output | 1 | One-clock strobe at count 0 of each period |
| pulse_o | output | 3 | Raw center-aligned pulses for channels A, B, C |
| set_pending_o | output | 1 | A complete set of on-times awaits the next boundary |

## Verification
The assertions take three things for granted. Periods written are at least 8 clocks, so the snapshot and calculation points fall inside the period and sync can never repeat on consecutive clocks. No write arrives while the internal reset is still being released. The status flag can only rise at count P-4. The stimulus meets these assumptions by writing only periods of 40 and 60. It also waits for the end of reset and times every write from the reference model's own count. Write times are chosen on purpose just before and inside the four-count window.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  // counts before the boundary at which a staged set is sampled
  localparam int unsigned SNAP_LEAD = 5;
  // counts before the boundary at which edges are computed
  localparam int unsigned CALC_LEAD = 4;
  // shortest legal period
  localparam int unsigned MIN_PER   = 8;
  // selector code of the period register
  localparam int unsigned SEL_PERIOD = 0;
endpackage

// File: rtl/pwm3_counter.sv
module pwm3_counter
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned PER_RST = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic             snap_o,
  output logic             calc_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] next_per_o
);
  localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(PER_RST);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, act_d;   // period running now
  logic [CNT_W-1:0] prg_q, prg_d;   // programmed period
  logic [CNT_W-1:0] nxt_q, nxt_d;   // period sampled for next cycle

  always_comb begin
    wrap_o = (cnt_q == act_q - CNT_W'(1));
    snap_o = (cnt_q == act_q - CNT_W'(SNAP_LEAD));
    calc_o = (cnt_q == act_q - CNT_W'(CALC_LEAD));
    prg_d  = per_we ? per_wdata : prg_q;
    nxt_d  = snap_o ? prg_d : nxt_q;
    cnt_d  = wrap_o ? '0 : cnt_q + CNT_W'(1);
    act_d  = wrap_o ? nxt_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= PER_INIT;
      prg_q <= PER_INIT;
      nxt_q <= PER_INIT;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      prg_q <= prg_d;
      nxt_q <= nxt_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign next_per_o = nxt_q;
endmodule

// File: rtl/pwm3_stage.sv
module pwm3_stage #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned NCH   = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [CNT_W-1:0]          wr_data,
  input  logic                      snap,
  input  logic                      wrap,
  output logic [NCH-1:0][CNT_W-1:0] calc_on_o,
  output logic                      pending_o
);
  logic [NCH-1:0][CNT_W-1:0] stg_q, stg_d;
  logic [NCH-1:0][CNT_W-1:0] cal_q, cal_d;
  logic [NCH-1:0]            flg_q, flg_d, flg_n;
  logic                      pend_q, pend_d;
  logic                      take;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit      = wr_en && (wr_sel == SEL_W'(i + 1));
    assign stg_d[i] = hit ? wr_data : stg_q[i];
    assign flg_d[i] = hit | flg_q[i];
  end

  always_comb begin
    take   = snap && (&flg_d);
    flg_n  = take ? '0 : flg_d;
    cal_d  = take ? stg_d : cal_q;
    pend_d = take ? 1'b1 : (wrap ? 1'b0 : pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      cal_q  <= '0;
      flg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      cal_q  <= cal_d;
      flg_q  <= flg_n;
      pend_q <= pend_d;
    end
  end

  assign calc_on_o = cal_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/pwm3_edge.sv
module pwm3_edge #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned PER_RST = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             calc_en,
  input  logic             load,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] on,
  input  logic [CNT_W-1:0] cnt,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] MID_INIT = CNT_W'(PER_RST / 2);

  logic [CNT_W-1:0] on_c, ton_c, toff_c;
  logic [CNT_W-1:0] sh_on_q, sh_on_d, sh_off_q, sh_off_d;
  logic [CNT_W-1:0] ac_on_q, ac_on_d, ac_off_q, ac_off_d;

  always_comb begin
    on_c     = (on >= per) ? per : on;
    ton_c    = (per - on_c) >> 1;
    toff_c   = ton_c + on_c;
    sh_on_d  = calc_en ? ton_c  : sh_on_q;
    sh_off_d = calc_en ? toff_c : sh_off_q;
    ac_on_d  = load ? sh_on_q  : ac_on_q;
    ac_off_d = load ? sh_off_q : ac_off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_on_q  <= MID_INIT;
      sh_off_q <= MID_INIT;
      ac_on_q  <= MID_INIT;
      ac_off_q <= MID_INIT;
    end else begin
      sh_on_q  <= sh_on_d;
      sh_off_q <= sh_off_d;
      ac_on_q  <= ac_on_d;
      ac_off_q <= ac_off_d;
    end
  end

  assign pulse_o = (cnt >= ac_on_q) && (cnt < ac_off_q);
endmodule

// File: rtl/pwm3_core.sv
module pwm3_core
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned NCH     = 3,
  parameter int unsigned PER_RST = 500,
  parameter int unsigned SEL_W   = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             sync_o,
  output logic [NCH-1:0]   pulse_o,
  output logic             set_pending_o
);
  logic [1:0]                rst_pipe;
  logic                      rst_int_n;
  logic [CNT_W-1:0]          cnt, next_per;
  logic                      snap, calc, wrap, per_we;
  logic [NCH-1:0][CNT_W-1:0] calc_on;
  logic                      pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign per_we = wr_en && (wr_sel == SEL_W'(SEL_PERIOD));

  pwm3_counter #(.CNT_W(CNT_W), .PER_RST(PER_RST)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .per_we(per_we), .per_wdata(wr_data),
    .cnt_o(cnt), .snap_o(snap), .calc_o(calc), .wrap_o(wrap),
    .next_per_o(next_per)
  );

  pwm3_stage #(.CNT_W(CNT_W), .NCH(NCH), .SEL_W(SEL_W)) u_stage (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .snap(snap), .wrap(wrap),
    .calc_on_o(calc_on), .pending_o(pending)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_edge
    pwm3_edge #(.CNT_W(CNT_W), .PER_RST(PER_RST)) u_edge (
      .clk(clk), .rst_n(rst_int_n), .calc_en(calc), .load(wrap && pending),
      .per(next_per), .on(calc_on[i]), .cnt(cnt), .pulse_o(pulse_o[i])
    );
  end

  assign sync_o        = (cnt == '0);
  assign set_pending_o = pending;
endmodule

// File: rtl/pwm3_core_chk.sv
module pwm3_core_chk #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned MIN_PER = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             sync_o,
  input logic             set_pending_o
);
  // R1: input assumption, period writes stay legal
  p_period_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == '0) |-> (wr_data >= CNT_W'(MIN_PER)));

  // R2: sync lasts a single clock
  p_sync_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);

  // R8: a set that was pending is consumed by the time sync shows
  p_pend_low_at_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> !set_pending_o);

  // R8: pending only drops into a sync clock
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_pending_o |=> (set_pending_o || sync_o));

  // R7: acceptance lands inside the window, never right before a sync
  p_pend_rise_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(set_pending_o) |=> !sync_o);
endmodule

bind pwm3_core pwm3_core_chk #(
  .CNT_W(CNT_W), .SEL_W(SEL_W), .MIN_PER(pwm3_pkg::MIN_PER)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .sync_o(sync_o), .set_pending_o(set_pending_o)
);

// File: tb/pwm3_core_tb_top.sv
module pwm3_core_tb_top;
  localparam int W = 12, NCH = 3, PR = 500;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, wr_en;
  logic [1:0]     wr_sel;
  logic [W-1:0]   wr_data;
  logic           sync_o, set_pending_o;
  logic [NCH-1:0] pulse_o;

  pwm3_core #(.CNT_W(W), .NCH(NCH), .PER_RST(PR)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sync_o(sync_o), .pulse_o(pulse_o),
    .set_pending_o(set_pending_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 0;

  // reference model
  int m_cnt, m_act, m_preg, m_nper, m_pend, rsd;
  int m_stage[NCH], m_flag[NCH], m_calc[NCH], m_ton[NCH], m_toff[NCH];

  task automatic m_edges(input int ch, input int on, input int p);
    int oc;
    oc = (on >= p) ? p : on;
    m_ton[ch]  = (p - oc) / 2;
    m_toff[ch] = m_ton[ch] + oc;
  endtask

  task automatic m_reset();
    m_cnt = 0; m_act = PR; m_preg = PR; m_nper = PR; m_pend = 0;
    for (int i = 0; i < NCH; i++) begin
      m_stage[i] = 0; m_flag[i] = 0; m_calc[i] = 0;
      m_edges(i, 0, PR);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rsd = 0; m_reset();
    end else if (rsd < 2) begin
      rsd++;
    end else begin
      int all;
      if (wr_en) begin
        if (wr_sel == 0) m_preg = int'(wr_data);
        else begin
          m_stage[wr_sel-1] = int'(wr_data);
          m_flag[wr_sel-1]  = 1;
        end
      end
      if (m_cnt == m_act - 5) begin
        m_nper = m_preg;
        all = 1;
        for (int i = 0; i < NCH; i++) if (m_flag[i] == 0) all = 0;
        if (all == 1) begin
          for (int i = 0; i < NCH; i++) begin m_calc[i] = m_stage[i]; m_flag[i] = 0; end
          m_pend = 1;
        end
      end
      if (m_cnt == m_act - 1) begin
        m_cnt = 0; m_act = m_nper;
        if (m_pend == 1) begin
          for (int i = 0; i < NCH; i++) m_edges(i, m_calc[i], m_nper);
          m_pend = 0;
        end
      end else m_cnt++;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check_eq("R2 sync", int'(sync_o), (m_cnt == 0) ? 1 : 0);
      for (int i = 0; i < NCH; i++)
        check_eq($sformatf("R3 pulse ch%0d", i), int'(pulse_o[i]),
                 (m_cnt >= m_ton[i] && m_cnt < m_toff[i]) ? 1 : 0);
      check_eq("R8 pending", int'(set_pending_o), m_pend);
    end
  end

  // period and width monitor
  int mc, mh[NCH], last_per, last_w[NCH];
  bit mon_started = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      if (sync_o) begin
        if (mon_started) begin
          last_per = mc;
          for (int i = 0; i < NCH; i++) last_w[i] = mh[i];
        end
        mon_started = 1; mc = 0;
        for (int i = 0; i < NCH; i++) mh[i] = 0;
      end
      mc++;
      for (int i = 0; i < NCH; i++) mh[i] += int'(pulse_o[i]);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_cnt(input int v);
    @(negedge clk);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_syncs(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!sync_o) @(negedge clk);
    end
    #1;
  endtask

  task automatic check_widths(input string tag, input int a, input int b, input int c);
    check_eq({tag, " width A"}, last_w[0], a);
    check_eq({tag, " width B"}, last_w[1], b);
    check_eq({tag, " width C"}, last_w[2], c);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    // R9: reset state
    check_eq("R9 sync after reset", int'(sync_o), 1);
    check_eq("R9 pulses after reset", int'(pulse_o), 0);
    check_eq("R9 pending after reset", int'(set_pending_o), 0);

    // R1 R3 R4: first commit, period 40
    wait_cnt(10);
    wr(0, 40); wr(1, 10); wr(2, 20); wr(3, 0);
    wait_syncs(2);
    check_eq("R1 period", last_per, 40);
    check_widths("R3/R4", 10, 20, 0);

    // R5: on-time at or above period
    wait_cnt(2);
    wr(1, 40); wr(2, 41); wr(3, 5);
    wait_syncs(2);
    check_widths("R5", 40, 40, 5);

    // R6: partial set has no effect
    wait_cnt(2);
    wr(1, 8); wr(2, 8);
    wait_syncs(2);
    check_widths("R6 partial", 40, 40, 5);
    check_eq("R6 pending after partial", int'(set_pending_o), 0);

    // R7: completing write inside the last four counts is deferred
    wait_cnt(37);
    wr(3, 8);
    wait_syncs(2);
    check_widths("R7 late", 40, 40, 5);
    wait_syncs(1);
    check_widths("R6 commit", 8, 8, 8);

    // R7 R8 R1: completing write at count P-5 is still on time
    wait_cnt(1);
    wr(0, 60);
    wait_cnt(3);
    wr(1, 12); wr(2, 14);
    wait_cnt(35);
    wr(3, 6);
    check_eq("R8 pending raised", int'(set_pending_o), 1);
    wait_syncs(2);
    check_eq("R1 period change", last_per, 60);
    check_widths("R7 timely", 12, 14, 6);

    wait_syncs(1);
    summary();
    $finish;
  end
endmodule